// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs an external sampling analog-to-digital converter that starts on a rising edge, reports its busy time on an end-of-conversion (EOC) flag and presents a 12-bit parallel word. The sequencer raises a start pulse whose width is set in clock cycles. It then follows EOC through a two-flop synchroniser, waits a set number of cycles after EOC drops so that the word has settled, and latches the word. The word leaves on a valid/ready port together with a running sample index.

A new conversion is launched either by a single-cycle trigger or by an internal pacing timer in free-running mode. No launch happens while a conversion is in flight, while the synchronised EOC is high, or while a delivered word still waits for its consumer. If EOC never drops, a timeout ends the attempt. If EOC rises when the sequencer did not start anything, the results of that period cannot be trusted: the block raises a sticky error and drops the next two results it would have delivered.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is held, adc_start, smp_valid, err_timeout and err_overlap are 0 and smp_index is 0.
- R2: Each start pulse stays high for exactly cfg_pulse_w clock cycles. A value of 0 is treated as 1.
- R3: A launch takes place only when the sequencer is idle, the synchronised EOC is low and no undelivered word is pending. A trigger that arrives while any of these conditions fails is dropped, so no start edge is ever produced while EOC is high.
- R4: smp_valid rises on the (4 + cfg_cap_dly)-th rising clock edge, counting as edge 1 the first edge at which adc_eoc is low at the end of a conversion that the block started.
- R5: smp_data equals adc_data as sampled on that capture edge, in straight binary with no change. 0x000 and 0xFFF pass through unchanged.
- R6: While smp_valid is high and smp_ready is low, smp_valid, smp_data and smp_index hold their values.
- R7: smp_index starts at 0 and advances by one, modulo 2^IDX_W, after each accepted word.
- R8: In free-running mode (cfg_free_run = 1), successive start edges are exactly cfg_period cycles apart, provided each conversion is delivered and accepted within the period.
- R9: In single-shot mode, one trigger cycle in a ready idle state produces a start edge on the next clock edge. No start is produced without a trigger.
- R10: If EOC has not fallen by the time cfg_timeout + 1 edges have passed after the launch edge, err_timeout pulses for one cycle on that edge. The block then returns to idle and delivers no word for that attempt. This assumes cfg_timeout is at least cfg_pulse_w.
- R11: A rising synchronised EOC seen while the block is idle or counting its capture delay sets err_overlap three edges after the raw rise. The flag stays set until reset, and the next two completed conversions are not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_free_run | input | 1 | 1 = paced free-running launches, 0 = single-shot on trig |
| cfg_period | input | PER_W | Free-running launch spacing in cycles |
| cfg_pulse_w | input | CNT_W | Start pulse width in cycles |
| cfg_cap_dly | input | CNT_W | Extra settle cycles between detected EOC fall and capture |
| cfg_timeout | input | TO_W | Cycles allowed from launch before giving up |
| trig | input | 1 | Single-shot launch request |
| adc_eoc | input | 1 | Converter busy flag (asynchronous) |
| adc_data | input | DATA_W | Converter parallel output word |
| adc_start | output | 1 | Start-convert pulse to the converter |
| smp_valid | output | 1 | Captured word available |
| smp_ready | input | 1 | Consumer accepts the word |
| smp_data | output | DATA_W | Captured word |
| smp_index | output | IDX_W | Running index of delivered words |
| err_timeout | output | 1 | One-cycle pulse on a conversion timeout |
| err_overlap | output | 1 | Sticky flag for an EOC rise the block did not cause |

## Verification
A stuck or mis-stepped sequencing state shows first on adc_start: a pulse that is too long or too short, a launch while EOC is high, or a second launch in the middle of a conversion. Each of these is visible on the clock edge where it happens. A miscount in the synchroniser or the capture delay moves the smp_valid rise by whole cycles. It also makes smp_data pick up the scrambled word that the converter model drives before its data is valid. Both show within one conversion. A wrong discard count or a flag that is not sticky appears as an extra or missing word, or as err_overlap dropping, on the next conversion after the fault.

// File: rtl/adc_seq_pkg.sv
// Shared types and constants for the conversion sequencer.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_CONV  = 2'd2,
        ST_CAPT  = 2'd3
    } seq_state_t;

    // Results dropped after an unexpected EOC rise.
    localparam int DISCARD_AFTER_FAULT = 2;
endpackage

// File: rtl/adc_eoc_sync.sv
// Brings the asynchronous busy flag into the clock domain through a flop
// chain and provides one-cycle rise and fall strobes of the synchronised level.
// Assumes the flag is held longer than one clock period.
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_async,
    output logic eoc_lvl,
    output logic eoc_rise,
    output logic eoc_fall
);
    logic [STAGES-1:0] chain;
    logic              lvl_q;

    // Shift the raw flag through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= eoc_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= chain[STAGES-1];
    end

    assign eoc_lvl  = chain[STAGES-1];
    assign eoc_rise = chain[STAGES-1] & ~lvl_q;
    assign eoc_fall = ~chain[STAGES-1] & lvl_q;
endmodule

// File: rtl/adc_pace_timer.sv
// Down-counter that spaces free-running launches. A launch reloads it with
// period-1 and it reports "done" once that many further cycles have passed.
module adc_pace_timer #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [PER_W-1:0] period,
    output logic             done
);
    logic [PER_W-1:0] remain;

    // Reload on launch, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (reload) begin
            remain <= (period == '0) ? '0 : period - 1'b1;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion state machine: launches, shapes the start pulse, follows the
// synchronised busy flag, times the settle delay, enforces the timeout and
// handles unexpected busy edges. Assumes cfg_timeout >= cfg_pulse_w and
// configuration held steady during a conversion.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TO_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_free_run,
    input  logic [CNT_W-1:0] cfg_pulse_w,
    input  logic [CNT_W-1:0] cfg_cap_dly,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             trig,
    input  logic             pace_done,
    input  logic             slot_free,
    input  logic             eoc_lvl,
    input  logic             eoc_rise,
    input  logic             eoc_fall,
    output logic             adc_start,
    output logic             launch,
    output logic             cap_now,
    output logic             err_timeout,
    output logic             err_overlap
);
    localparam logic [1:0] DISC_LOAD = 2'(DISCARD_AFTER_FAULT);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [TO_W-1:0]  to_cnt;
    logic             seen_busy;
    logic [1:0]       discard;
    logic             want;

    // Pick the launch source and gate it with every launch condition.
    always_comb begin
        want    = cfg_free_run ? pace_done : trig;
        launch  = want && (state == ST_IDLE) && !eoc_lvl && slot_free;
        cap_now = (state == ST_CAPT) && (cnt == '0) && (discard == '0);
    end

    // Sequence one conversion from launch to capture or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            adc_start   <= 1'b0;
            cnt         <= '0;
            to_cnt      <= '0;
            seen_busy   <= 1'b0;
            discard     <= '0;
            err_timeout <= 1'b0;
            err_overlap <= 1'b0;
        end else begin
            err_timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state     <= ST_PULSE;
                        adc_start <= 1'b1;
                        cnt       <= (cfg_pulse_w == '0) ? '0 : cfg_pulse_w - 1'b1;
                        to_cnt    <= cfg_timeout;
                        seen_busy <= 1'b0;
                    end
                end
                ST_PULSE: begin
                    if (eoc_rise) seen_busy <= 1'b1;
                    if (to_cnt != '0) to_cnt <= to_cnt - 1'b1;
                    if (cnt == '0) begin
                        adc_start <= 1'b0;
                        state     <= ST_CONV;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (eoc_rise) seen_busy <= 1'b1;
                    if (eoc_fall && seen_busy) begin
                        state <= ST_CAPT;
                        cnt   <= cfg_cap_dly;
                    end else if (to_cnt == '0) begin
                        state       <= ST_IDLE;
                        err_timeout <= 1'b1;
                    end else begin
                        to_cnt <= to_cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        if (discard != '0) discard <= discard - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
            // Busy edge the block did not cause: flag and arm the discard.
            if (eoc_rise && (state == ST_IDLE || state == ST_CAPT)) begin
                err_overlap <= 1'b1;
                discard     <= DISC_LOAD;
            end
        end
    end

    // R3: no start edge while a conversion is in flight.
    a_r3_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !$rose(adc_start));

    // R3: a start edge only follows a low synchronised busy flag.
    a_r3_idle_eoc_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> !$past(eoc_lvl));

    // R11: the overlap flag never clears outside reset.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |=> err_overlap);
endmodule

// File: rtl/adc_out_hold.sv
// Output register holding one captured word with its index until the
// consumer accepts it. Assumes a capture never arrives while a word is held.
module adc_out_hold #(
    parameter int DATA_W = 12,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  idx
);
    // Load on capture, release and advance the index on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            idx   <= '0;
        end else if (cap) begin
            valid <= 1'b1;
            data  <= din;
        end else if (valid && ready) begin
            valid <= 1'b0;
            idx   <= idx + 1'b1;
        end
    end

    // R6: held word stays put under back-pressure.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data) && $stable(idx)));

    // R7: each accepted word advances the index by one.
    a_r7_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/adc_conv_seq.sv
// Top of the conversion sequencer: synchroniser, pacing timer, state
// machine and output register. Assumes the converter presents settled data
// no later than cfg_cap_dly+3 cycles after its busy flag drops.
module adc_conv_seq #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 8,
    parameter int PER_W  = 12,
    parameter int TO_W   = 12,
    parameter int IDX_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_free_run,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic [CNT_W-1:0]  cfg_pulse_w,
    input  logic [CNT_W-1:0]  cfg_cap_dly,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic              trig,
    input  logic              adc_eoc,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_start,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [DATA_W-1:0] smp_data,
    output logic [IDX_W-1:0]  smp_index,
    output logic              err_timeout,
    output logic              err_overlap
);
    logic eoc_lvl, eoc_rise, eoc_fall;
    logic pace_done, launch, cap_now;

    adc_eoc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc_async (adc_eoc),
        .eoc_lvl   (eoc_lvl),
        .eoc_rise  (eoc_rise),
        .eoc_fall  (eoc_fall)
    );

    adc_pace_timer #(.PER_W(PER_W)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (launch),
        .period (cfg_period),
        .done   (pace_done)
    );

    adc_seq_ctrl #(.CNT_W(CNT_W), .TO_W(TO_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_free_run (cfg_free_run),
        .cfg_pulse_w  (cfg_pulse_w),
        .cfg_cap_dly  (cfg_cap_dly),
        .cfg_timeout  (cfg_timeout),
        .trig         (trig),
        .pace_done    (pace_done),
        .slot_free    (!smp_valid),
        .eoc_lvl      (eoc_lvl),
        .eoc_rise     (eoc_rise),
        .eoc_fall     (eoc_fall),
        .adc_start    (adc_start),
        .launch       (launch),
        .cap_now      (cap_now),
        .err_timeout  (err_timeout),
        .err_overlap  (err_overlap)
    );

    adc_out_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_now),
        .din   (adc_data),
        .ready (smp_ready),
        .valid (smp_valid),
        .data  (smp_data),
        .idx   (smp_index)
    );

    // R10: a timeout never coincides with a fresh capture.
    a_r10_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !$rose(smp_valid));
endmodule

// File: tb/adc_conv_seq_test.sv
`timescale 1ns/1ps
// Bench: behavioural converter model plus a per-cycle reference model.
module adc_conv_seq_test;
    localparam int IDXW = 3;
    localparam int RISE = 3, CONVT = 20, DV = 2;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_free_run = 1'b0;
    logic [11:0] cfg_period = 12'd40;
    logic [7:0] cfg_pulse_w = 8'd4;
    logic [7:0] cfg_cap_dly = 8'd2;
    logic [11:0] cfg_timeout = 12'd200;
    logic trig = 1'b0;
    logic adc_eoc = 1'b0;
    logic [11:0] adc_data = '0;
    logic adc_start, smp_valid, err_timeout, err_overlap;
    logic smp_ready = 1'b1;
    logic [11:0] smp_data;
    logic [IDXW-1:0] smp_index;

    always #2.5 clk = ~clk;

    adc_conv_seq #(.IDX_W(IDXW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_free_run(cfg_free_run),
        .cfg_period(cfg_period), .cfg_pulse_w(cfg_pulse_w),
        .cfg_cap_dly(cfg_cap_dly), .cfg_timeout(cfg_timeout), .trig(trig),
        .adc_eoc(adc_eoc), .adc_data(adc_data), .adc_start(adc_start),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .smp_index(smp_index), .err_timeout(err_timeout),
        .err_overlap(err_overlap)
    );

    int errors = 0, checks = 0, n_steps = 0;
    // reference model state
    bit exp_valid, exp_start, exp_to, exp_ov, m_idle;
    int exp_data, exp_idx, cap_val, cd, pw_cd, to_cd, ov_cd, disc;
    // converter model state
    bit eoc_q, start_q, active, mute;
    int st, cur_val, pw_meas, last_rise;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at step %0d: actual=%0h expected=%0h", req, n_steps, act, exp);
        end
    endtask

    task automatic model_clear();
        exp_valid = 0; exp_start = 0; exp_to = 0; exp_ov = 0; m_idle = 1;
        exp_data = 0; exp_idx = 0; cap_val = 0; cd = 0; pw_cd = 0;
        to_cd = 0; ov_cd = 0; disc = 0;
        eoc_q = 0; start_q = 0; active = 0; st = 0; pw_meas = 0; last_rise = -1;
        adc_eoc = 0; adc_data = '0;
    endtask

    task automatic step();
        bit launch;
        int pw_eff;
        @(posedge clk); #1;
        n_steps++;
        if (n_steps > WATCHDOG) begin
            errors++; checks++;
            $display("FAIL watchdog expired at step %0d", n_steps);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (rst_n) begin
            pw_eff = (cfg_pulse_w == 0) ? 1 : int'(cfg_pulse_w);
            launch = !cfg_free_run && trig && m_idle && !eoc_q && !exp_valid;
            if (exp_valid && smp_ready) begin
                exp_valid = 0; exp_idx = (exp_idx + 1) % (1 << IDXW);
            end
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    m_idle = 1;
                    if (disc > 0) disc--;
                    else begin exp_valid = 1; exp_data = cap_val; end
                end
            end
            if (exp_start) begin
                pw_cd--; if (pw_cd == 0) exp_start = 0;
            end
            exp_to = 0;
            if (to_cd > 0) begin
                to_cd--;
                if (to_cd == 0) begin exp_to = 1; m_idle = 1; end
            end
            if (launch) begin
                exp_start = 1; pw_cd = pw_eff; m_idle = 0;
                to_cd = int'(cfg_timeout) + 1;
            end
            if (ov_cd > 0) begin
                ov_cd--; if (ov_cd == 0) exp_ov = 1;
            end
            // per-cycle comparisons
            chk(smp_valid == exp_valid, "R4 valid timing", smp_valid, exp_valid);
            if (exp_valid) begin
                chk(smp_data == exp_data[11:0], "R5 data", smp_data, exp_data);
                chk(int'(smp_index) == exp_idx, "R7 index", smp_index, exp_idx);
            end
            if (!cfg_free_run) chk(adc_start == exp_start, "R9 start", adc_start, exp_start);
            chk(err_timeout == exp_to, "R10 timeout", err_timeout, exp_to);
            chk(err_overlap == exp_ov, "R11 overlap", err_overlap, exp_ov);
            // converter model
            if (adc_start && !start_q) begin
                chk(eoc_q == 0, "R3 start while busy", eoc_q, 0);
                if (cfg_free_run && last_rise >= 0)
                    chk(n_steps - last_rise == int'(cfg_period), "R8 spacing",
                        n_steps - last_rise, cfg_period);
                last_rise = n_steps;
                pw_meas = 0;
                if (!mute) begin
                    active = 1; st = 0; adc_data = ~cur_val[11:0];
                end
            end
            if (adc_start) pw_meas++;
            if (!adc_start && start_q)
                chk(pw_meas == pw_eff, "R2 pulse width", pw_meas, pw_eff);
            start_q = adc_start;
            if (active) begin
                st++;
                if (st == RISE) eoc_q = 1;
                if (st == RISE + CONVT) begin
                    eoc_q = 0; cd = 4 + int'(cfg_cap_dly); to_cd = 0; cap_val = cur_val;
                end
                if (st == RISE + CONVT + DV) begin
                    adc_data = cur_val[11:0]; active = 0;
                end
            end
            adc_eoc = eoc_q;
        end
    endtask

    task automatic do_reset();
        rst_n = 0; mute = 0;
        model_clear();
        repeat (3) step();
        // R1: reset state
        chk(adc_start == 0, "R1 start", adc_start, 0);
        chk(smp_valid == 0, "R1 valid", smp_valid, 0);
        chk(err_timeout == 0 && err_overlap == 0, "R1 errors", {err_timeout, err_overlap}, 0);
        chk(smp_index == 0, "R1 index", smp_index, 0);
        rst_n = 1;
    endtask

    task automatic go(input int v);
        cur_val = v; trig = 1; step(); trig = 0;
        repeat (40) step();
    endtask

    initial begin
        cur_val = 0;
        do_reset();
        // single-shot, boundary codes (R5, R9)
        go(12'h000); go(12'hFFF); go(12'hA5C); go(12'h123);
        // trigger during a conversion is dropped (R3)
        cur_val = 12'h800; trig = 1; step(); trig = 0;
        repeat (8) step(); trig = 1; step(); trig = 0;
        repeat (40) step();
        // no trigger, no start (R9)
        repeat (20) step();
        // back-pressure holds the word and blocks launches (R6, R3)
        smp_ready = 0; go(12'h3C3);
        trig = 1; step(); trig = 0; repeat (5) step();
        smp_ready = 1; repeat (5) step();
        // zero settle delay and zero pulse width (R4, R2)
        cfg_cap_dly = 8'd0; cfg_pulse_w = 8'd0;
        go(12'h5A5); go(12'h0F0);
        // index wrap (R7)
        for (int i = 0; i < 6; i++) go(i * 12'h111 + 1);
        // timeout with a silent converter (R10)
        cfg_timeout = 12'd30; cfg_pulse_w = 8'd4; cfg_cap_dly = 8'd2;
        mute = 1; go(12'h777); mute = 0;
        go(12'h456);
        // unexpected busy rise, refused launches, two drops (R11, R3)
        eoc_q = 1; adc_eoc = 1; ov_cd = 3; disc = 2;
        repeat (5) step();
        for (int i = 0; i < 3; i++) begin trig = 1; step(); trig = 0; repeat (4) step(); end
        eoc_q = 0; adc_eoc = 0; repeat (5) step();
        go(12'h111); go(12'h222); go(12'h333);
        // free-running pacing (R8)
        cfg_free_run = 1; cfg_period = 12'd40;
        do_reset();
        cur_val = 12'h9AB;
        repeat (300) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule